// File: doc/BRIEF.md
# FSK Byte Framer

This block sits between a host register interface and a downstream FSK tone synthesizer. It turns host bytes into an asynchronous serial stream at a fixed baud rate. It does not produce tones. It supplies one serial bit and a strobe that marks the start of every new bit period. The synthesizer maps a 1 (mark) and a 0 (space) to its two tones.

The host holds one byte in a data register. It raises a handshake flag to offer that byte. While the block runs and its internal queue has a free stage, the block copies the byte into the queue and drops the flag. The host then loads the next byte.

Each queued byte goes out framed as follows:
- a low start bit,
- eight data bits, least significant first,
- a high stop bit.

With nothing queued, the line rests at mark. Bit timing comes from a sample-rate tick through a fractional accumulator, so the average bit period is exact. Clearing the enable lets queued data finish before the block halts. If the block is idle when the enable clears, it halts at the next bit boundary.

Top module: `fsk_byte_framer`

## Requirements
- R1: When `en_i` is high and the block is stopped, `active_o` rises on the next clock and `ser_o` holds mark (1) from then until the first bit boundary.
- R2: While `active_o` is low, `ser_o` is 1 and `bit_stb_o` is 0.
- R3: `flag_set_i` sets `flag_o`. The flag clears only when the held byte moves into a free queue stage, which needs `en_i` high and `active_o` high. While all stages are full, the flag stays set.
- R4: With BUF_DEPTH = 3 and no bit boundaries, three offered bytes are each accepted. A fourth stays pending in the data register with `flag_o` still 1, for four pending bytes in total.
- R5: Each byte is sent as a frame of ten bits in this order: a start bit of 0, data bit 0 through data bit 7, then a stop bit of 1. Bytes are sent in the order they were accepted.
- R6: An accumulator adds BAUD to itself on every `sample_tick_i` while the block is active. It wraps modulo TICK_HZ, and each wrap is a bit boundary. The k-th boundary after `active_o` rises therefore falls on active tick number ceil(k·TICK_HZ/BAUD).
- R7: When no byte is queued at a bit boundary and the block stays enabled, the next bit is mark. When a byte is queued at the boundary that ends a stop bit, its start bit follows at once, with no mark bit between the frames.
- R8: After `en_i` falls with bytes queued or in flight, every accepted byte is sent in full. `active_o` then falls at the boundary that ends the last stop bit, with no extra mark bit.
- R9: After `en_i` falls while the block is idling at mark with nothing queued, `active_o` falls at the next bit boundary. That is at most ceil(TICK_HZ/BAUD) active ticks later.
- R10: A flag raised while `en_i` is low moves no data. `flag_o` stays 1 until the block is enabled and a stage is free, and then the byte is accepted and sent.
- R11: `bit_stb_o` pulses for one clock at every bit boundary where the block stays active. Between pulses, `ser_o` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Run enable from the host |
| sample_tick_i | input | 1 | One-clock strobe at the sample rate (TICK_HZ) |
| data_wr_i | input | 1 | Write strobe for the held data register |
| data_i | input | 8 | Byte to hold |
| flag_set_i | input | 1 | Raises the handshake flag to offer the held byte |
| flag_o | output | 1 | Handshake flag; 1 while the held byte is still pending |
| ser_o | output | 1 | Serial bit to the tone synthesizer, 1 = mark |
| bit_stb_o | output | 1 | One-clock pulse when a new bit period begins |
| active_o | output | 1 | High while the block is running |

## Verification
The bench builds the block with its default values: an 8000 Hz tick, 1200 baud and a three-stage queue. Under these values a bit period lasts 6 or 7 ticks in a repeating 7-7-6 pattern. The bench checks every boundary against ceil(k·8000/1200), which exposes any drift or rounding error in the accumulator. The short queue can be filled completely by four host writes with the tick held off, which makes the full-queue flag behaviour visible. All 256 byte values are then streamed back to back, followed by a drain on disable and a sweep of twenty disable offsets within the idle mark.

// File: rtl/fskf_pkg.sv
package fskf_pkg;

    localparam int unsigned BYTE_W  = 8;
    localparam int unsigned FRAME_W = BYTE_W + 2;
    localparam int unsigned IDX_W   = $clog2(FRAME_W);

    localparam logic MARK  = 1'b1;
    localparam logic SPACE = 1'b0;

    typedef logic [BYTE_W-1:0]  byte_t;
    typedef logic [FRAME_W-1:0] frame_bits_t;

    // Frame in flight: remaining bits shift toward bit 0
    typedef struct packed {
        logic             busy;
        logic [IDX_W-1:0] idx;
        frame_bits_t      shreg;
    } frame_t;

    // Registered line state presented at the outputs
    typedef struct packed {
        logic active;
        logic ser;
        logic stb;
    } line_t;

    // Start bit in position 0, stop bit at the top
    function automatic frame_bits_t build_frame(input byte_t b);
        return {MARK, b, SPACE};
    endfunction

endpackage

// File: rtl/fskf_bitclk.sv
module fskf_bitclk #(
    parameter int unsigned TICK_HZ = 8000,
    parameter int unsigned BAUD    = 1200
) (
    input  logic clk,
    input  logic rst,
    input  logic run_i,
    input  logic tick_i,
    output logic bound_o
);

    localparam int unsigned ACC_W = $clog2(TICK_HZ + BAUD + 1);

    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] sum;

    assign sum     = acc_q + ACC_W'(BAUD);
    assign bound_o = run_i && tick_i && (sum >= ACC_W'(TICK_HZ));

    always_ff @(posedge clk) begin
        if (rst || !run_i) begin
            acc_q <= '0;
        end else if (tick_i) begin
            acc_q <= bound_o ? (sum - ACC_W'(TICK_HZ)) : sum;
        end
    end

    // R6
    acc_range_chk: assert property (@(posedge clk) disable iff (rst)
        acc_q < ACC_W'(TICK_HZ));

    // R6
    idle_acc_chk: assert property (@(posedge clk) disable iff (rst)
        !run_i |=> acc_q == '0);

endmodule

// File: rtl/fskf_queue.sv
module fskf_queue
    import fskf_pkg::*;
#(
    parameter int unsigned DEPTH = 3
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  push_i,
    input  logic  pop_i,
    input  byte_t din_i,
    output byte_t dout_o,
    output logic  full_o,
    output logic  empty_o
);

    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CNT_W = $clog2(DEPTH + 1);

    byte_t            mem_q [DEPTH];
    logic [PTR_W-1:0] wr_q;
    logic [PTR_W-1:0] rd_q;
    logic [CNT_W-1:0] cnt_q;

    function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (push_i) begin
            mem_q[wr_q] <= din_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_q  <= '0;
            rd_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (push_i) wr_q <= ptr_next(wr_q);
            if (pop_i)  rd_q <= ptr_next(rd_q);
            cnt_q <= cnt_q + CNT_W'(push_i) - CNT_W'(pop_i);
        end
    end

    assign dout_o  = mem_q[rd_q];
    assign full_o  = (cnt_q == CNT_W'(DEPTH));
    assign empty_o = (cnt_q == '0);

    // R4
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        push_i |-> !full_o);

    // R5
    no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
        pop_i |-> !empty_o);

endmodule

// File: rtl/fskf_seq.sv
module fskf_seq
    import fskf_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  en_i,
    input  logic  bound_i,
    input  logic  q_empty_i,
    input  byte_t q_data_i,
    output logic  pop_o,
    output logic  ser_o,
    output logic  bit_stb_o,
    output logic  active_o
);

    frame_t fr_q, fr_d;
    line_t  ln_q, ln_d;

    always_comb begin
        fr_d     = fr_q;
        ln_d     = ln_q;
        ln_d.stb = 1'b0;
        pop_o    = 1'b0;
        if (!ln_q.active) begin
            fr_d     = '0;
            ln_d.ser = MARK;
            if (en_i) ln_d.active = 1'b1;
        end else if (bound_i) begin
            if (fr_q.busy && fr_q.idx != IDX_W'(FRAME_W - 1)) begin
                // next bit of the current frame
                fr_d.idx   = fr_q.idx + 1'b1;
                fr_d.shreg = fr_q.shreg >> 1;
                ln_d.ser   = fr_q.shreg[1];
                ln_d.stb   = 1'b1;
            end else if (!q_empty_i) begin
                // open the next frame straight after the stop bit or idle mark
                pop_o      = 1'b1;
                fr_d.busy  = 1'b1;
                fr_d.idx   = '0;
                fr_d.shreg = build_frame(q_data_i);
                ln_d.ser   = fr_d.shreg[0];
                ln_d.stb   = 1'b1;
            end else if (en_i) begin
                fr_d     = '0;
                ln_d.ser = MARK;
                ln_d.stb = 1'b1;
            end else begin
                fr_d        = '0;
                ln_d.active = 1'b0;
                ln_d.ser    = MARK;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fr_q <= '0;
            ln_q <= '{active: 1'b0, ser: MARK, stb: 1'b0};
        end else begin
            fr_q <= fr_d;
            ln_q <= ln_d;
        end
    end

    assign ser_o     = ln_q.ser;
    assign bit_stb_o = ln_q.stb;
    assign active_o  = ln_q.active;

    // R1
    wake_chk: assert property (@(posedge clk) disable iff (rst)
        !ln_q.active && en_i |=> ln_q.active && ln_q.ser);

    // R2
    stopped_mark_chk: assert property (@(posedge clk) disable iff (rst)
        !ln_q.active |-> ln_q.ser && !ln_q.stb);

    // R5
    start_space_chk: assert property (@(posedge clk) disable iff (rst)
        pop_o |=> !ln_q.ser && ln_q.stb);

    // R8
    halt_empty_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(ln_q.active) |-> $past(q_empty_i) && !$past(en_i));

    // R11
    hold_between_chk: assert property (@(posedge clk) disable iff (rst)
        ln_q.active && $past(ln_q.active) && !ln_q.stb |-> $stable(ln_q.ser));

endmodule

// File: rtl/fsk_byte_framer.sv
module fsk_byte_framer
    import fskf_pkg::*;
#(
    parameter int unsigned TICK_HZ   = 8000,
    parameter int unsigned BAUD      = 1200,
    parameter int unsigned BUF_DEPTH = 3
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       en_i,
    input  logic       sample_tick_i,
    input  logic       data_wr_i,
    input  logic [7:0] data_i,
    input  logic       flag_set_i,
    output logic       flag_o,
    output logic       ser_o,
    output logic       bit_stb_o,
    output logic       active_o
);

    byte_t hold_q;
    logic  flag_q;
    logic  xfer;
    logic  q_full;
    logic  q_empty;
    logic  q_pop;
    logic  bound;
    byte_t q_data;

    assign xfer = flag_q && en_i && active_o && !q_full;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q <= '0;
            flag_q <= 1'b0;
        end else begin
            if (data_wr_i) hold_q <= data_i;
            flag_q <= flag_set_i | (flag_q & ~xfer);
        end
    end

    assign flag_o = flag_q;

    fskf_bitclk #(
        .TICK_HZ (TICK_HZ),
        .BAUD    (BAUD)
    ) u_bitclk (
        .clk     (clk),
        .rst     (rst),
        .run_i   (active_o),
        .tick_i  (sample_tick_i),
        .bound_o (bound)
    );

    fskf_queue #(
        .DEPTH (BUF_DEPTH)
    ) u_queue (
        .clk     (clk),
        .rst     (rst),
        .push_i  (xfer),
        .pop_i   (q_pop),
        .din_i   (hold_q),
        .dout_o  (q_data),
        .full_o  (q_full),
        .empty_o (q_empty)
    );

    fskf_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .en_i      (en_i),
        .bound_i   (bound),
        .q_empty_i (q_empty),
        .q_data_i  (q_data),
        .pop_o     (q_pop),
        .ser_o     (ser_o),
        .bit_stb_o (bit_stb_o),
        .active_o  (active_o)
    );

    // R10
    flag_park_chk: assert property (@(posedge clk) disable iff (rst)
        flag_q && !en_i |=> flag_q);

    // R3
    flag_wait_chk: assert property (@(posedge clk) disable iff (rst)
        flag_q && q_full && !q_pop |=> flag_q);

    // R3
    flag_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(flag_q) |-> $past(en_i) && !$past(q_full));

endmodule

// File: tb/fsk_byte_framer_tb.sv
module fsk_byte_framer_tb;

    localparam int TICK_HZ = 8000;
    localparam int BAUD    = 1200;
    localparam int MAX_TK  = (TICK_HZ + BAUD - 1) / BAUD;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en = 1'b0;
    logic       tick = 1'b0;
    logic       dwr = 1'b0;
    logic [7:0] din = '0;
    logic       fset = 1'b0;
    logic       flag_o, ser_o, bit_stb_o, active_o;

    always #2.5 clk = ~clk;

    fsk_byte_framer #(
        .TICK_HZ   (TICK_HZ),
        .BAUD      (BAUD),
        .BUF_DEPTH (3)
    ) u_dut (
        .clk           (clk),
        .rst           (rst),
        .en_i          (en),
        .sample_tick_i (tick),
        .data_wr_i     (dwr),
        .data_i        (din),
        .flag_set_i    (fset),
        .flag_o        (flag_o),
        .ser_o         (ser_o),
        .bit_stb_o     (bit_stb_o),
        .active_o      (active_o)
    );

    int n_vec = 0;
    int n_bad = 0;
    logic [7:0] tx_mem [0:511];
    int tx_n = 0;
    int rx_n = 0;
    bit tick_on = 1'b0;
    int gap_from = 1 << 30;
    int gap_until = 0;
    int tcnt = 0, kbit = 0, dec_idx = -1, idle_bits = 0, divc = 0;
    int stops = 0, stop_tcnt = 0, stop_idle = 0;
    logic [7:0] dec_byte = '0;
    logic prev_act = 1'b0, last_ser = 1'b1;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic host_write(input logic [7:0] b);
        while (flag_o) step();
        dwr = 1'b1;
        din = b;
        step();
        dwr  = 1'b0;
        fset = 1'b1;
        tx_mem[tx_n] = b;
        tx_n++;
        step();
        fset = 1'b0;
    endtask

    // Line monitor and tick source, all at the falling edge
    initial begin
        forever begin
            @(negedge clk);
            if (!rst) begin
                if (tick && prev_act) tcnt++;
                if (active_o && !prev_act) begin
                    tcnt = 0; kbit = 0; dec_idx = -1; idle_bits = 0;
                end
                if (!active_o) begin
                    if (ser_o !== 1'b1 || bit_stb_o !== 1'b0)
                        check(0, "R2", int'(ser_o), 1);
                end else if (bit_stb_o) begin
                    kbit++;
                    // R6 boundary k lands on tick ceil(k*TICK_HZ/BAUD)
                    check(tcnt == (kbit * TICK_HZ + BAUD - 1) / BAUD, "R6",
                          tcnt, (kbit * TICK_HZ + BAUD - 1) / BAUD);
                    if (dec_idx < 0) begin
                        if (ser_o == 1'b0) begin
                            if (rx_n >= gap_from && rx_n < gap_until)
                                check(idle_bits == 0, "R7", idle_bits, 0);
                            dec_idx = 0;
                            dec_byte = '0;
                        end else begin
                            idle_bits++;
                        end
                    end else if (dec_idx < 8) begin
                        dec_byte[dec_idx] = ser_o;
                        dec_idx++;
                    end else begin
                        check(ser_o == 1'b1, "R5 stop bit", int'(ser_o), 1);
                        check(dec_byte == tx_mem[rx_n], "R5 byte", int'(dec_byte),
                              int'(tx_mem[rx_n]));
                        rx_n++;
                        dec_idx = -1;
                        idle_bits = 0;
                    end
                end else if (prev_act && ser_o !== last_ser) begin
                    check(0, "R11", int'(ser_o), int'(last_ser));
                end
                if (prev_act && !active_o) begin
                    stop_tcnt = tcnt;
                    stop_idle = idle_bits;
                    stops++;
                    check(dec_idx < 0, "R8 frame cut", dec_idx, -1);
                end
                last_ser = ser_o;
                prev_act = active_o;
            end
            if (tick_on) begin
                divc = (divc == 2) ? 0 : divc + 1;
                tick = (divc == 0);
            end else begin
                tick = 1'b0;
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_vec++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        int mark_t;
        int st0;
        repeat (4) step();
        rst = 1'b0;
        step();
        check(active_o == 1'b0, "R2 reset active", int'(active_o), 0);
        check(ser_o == 1'b1, "R2 reset ser", int'(ser_o), 1);
        check(bit_stb_o == 1'b0, "R2 reset stb", int'(bit_stb_o), 0);
        check(flag_o == 1'b0, "R3 reset flag", int'(flag_o), 0);

        // R10: offer while disabled
        host_write(8'hA5);
        tick_on = 1'b1;
        repeat (30) step();
        check(flag_o == 1'b1, "R10 flag parked", int'(flag_o), 1);
        check(active_o == 1'b0, "R10 still stopped", int'(active_o), 0);
        tick_on = 1'b0;
        repeat (3) step();

        // R1: wake
        en = 1'b1;
        step();
        check(active_o == 1'b1, "R1 active", int'(active_o), 1);
        check(ser_o == 1'b1, "R1 mark", int'(ser_o), 1);
        repeat (3) step();
        check(flag_o == 1'b0, "R10 accepted once enabled", int'(flag_o), 0);

        // R3/R4: fill the queue with no boundaries
        host_write(8'h5A);
        host_write(8'hF0);
        repeat (3) step();
        check(flag_o == 1'b0, "R3 third stage taken", int'(flag_o), 0);
        host_write(8'h0F);
        repeat (10) step();
        check(flag_o == 1'b1, "R4 fourth pending", int'(flag_o), 1);
        check(rx_n == 0, "R4 nothing sent", rx_n, 0);
        tick_on = 1'b1;
        while (rx_n < 4) step();
        check(flag_o == 1'b0, "R3 flag freed", int'(flag_o), 0);

        // R5/R7: every byte value, back to back
        gap_from  = rx_n + 1;
        gap_until = rx_n + 256;
        for (int b = 0; b < 256; b++) host_write(8'(b));
        while (rx_n < tx_n) step();
        check(rx_n == tx_n, "R5 sweep count", rx_n, tx_n);

        // R8: drain on disable
        st0 = stops;
        host_write(8'h3C);
        host_write(8'hC3);
        host_write(8'h81);
        while (flag_o) step();
        en = 1'b0;
        while (stops == st0) step();
        check(rx_n == tx_n, "R8 drained", rx_n, tx_n);
        check(stop_idle == 0, "R8 no trailing mark", stop_idle, 0);

        // R9/R1: disable while idling, swept offsets
        for (int d = 0; d < 20; d++) begin
            en = 1'b1;
            step();
            check(active_o == 1'b1, "R1 rewake", int'(active_o), 1);
            repeat (d * 3 + 40) step();
            st0 = stops;
            mark_t = tcnt;
            en = 1'b0;
            while (stops == st0) step();
            check(stop_tcnt - mark_t <= MAX_TK, "R9 stop within a bit",
                  stop_tcnt - mark_t, MAX_TK);
            check(ser_o == 1'b1, "R2 mark after stop", int'(ser_o), 1);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule